// File: doc/BRIEF.md
# SPI Pin Direction and Mode Router

This block sits between the four pads of a serial peripheral port and the shift engine behind them. It reads five control bits: port enable, master/slave role, one-wire mode, shared-pin drive and fault-detect enable. From these it decides which pads the port owns and which it drives. It also decides which pad feeds the engine's serial input and which pad carries the engine's serial output, clock and slave-select. A pad that the port does not own goes back to general-purpose I/O. For such a pad the router holds its own output enable and output value at zero.

In the normal two-wire arrangement the two data pads keep fixed roles that swap between master and slave. In one-wire mode the router uses a single data pad for both directions. The master uses the master-out pad and the slave uses the master-in pad, and the other data pad is released. The drive bit then sets the direction of the shared pad. The engine's input always comes from that pad, so while it drives, the engine sees its own transmitted bits. The slave-select pad is an active-low input. In slave role it goes to the engine. In master role it goes to the fault detector when fault detection is enabled, and otherwise it is released.

The router is purely combinational and has no clock or state.

Top module: `spi_pin_router`

## Requirements
- R1: With `spi_en` = 0, every `*_spi_own`, `*_pad_oe` and `*_pad_o` is 0, `eng_rx` and `eng_sclk_rx` are 0, and `eng_ss_n` and `fault_ss_n` are 1, whatever the other inputs are.
- R2: When enabled, the clock pad is owned. As master it has `sclk_pad_oe` = 1, `sclk_pad_o` = `eng_sclk_drv` and `eng_sclk_rx` = 0. As slave it has `sclk_pad_oe` = 0, `sclk_pad_o` = 0 and `eng_sclk_rx` = `sclk_pad_i`.
- R3: In two-wire master mode (`one_wire_sel` = 0, `mstr_sel` = 1), the MOSI pad is owned with oe = 1 and drives `eng_tx`. The MISO pad is owned with oe = 0 and out = 0, and `eng_rx` = `miso_pad_i`.
- R4: In two-wire slave mode, the MISO pad is owned with oe = 1 and drives `eng_tx`. The MOSI pad is owned with oe = 0 and out = 0, and `eng_rx` = `mosi_pad_i`.
- R5: In one-wire master mode, the MOSI pad is owned and the MISO pad is released.
- R6: In one-wire slave mode, the MISO pad is owned and the MOSI pad is released.
- R7: In one-wire mode, the shared pad has oe = `bidir_drive`, and out = `eng_tx` when `bidir_drive` = 1 and 0 otherwise. In two-wire mode, `bidir_drive` has no effect on any output.
- R8: In one-wire mode, `eng_rx` equals the shared pad's input in both directions.
- R9: In slave role, the slave-select pad is owned, `eng_ss_n` = `ss_pad_n_i` and `fault_ss_n` = 1, whatever `fault_det_en` is.
- R10: In master role with `fault_det_en` = 0, the slave-select pad is released and both `eng_ss_n` and `fault_ss_n` are 1.
- R11: In master role with `fault_det_en` = 1, the slave-select pad is owned, `fault_ss_n` = `ss_pad_n_i` and `eng_ss_n` = 1.
- R12: Any data or clock pad with own = 0 also has oe = 0 and out = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| spi_en | input | 1 | Port enable |
| mstr_sel | input | 1 | 1 = master role, 0 = slave role |
| one_wire_sel | input | 1 | 1 = one-wire bidirectional data |
| bidir_drive | input | 1 | Shared-pad direction in one-wire mode, 1 = output |
| fault_det_en | input | 1 | Route slave-select to fault detector in master role |
| sclk_pad_i | input | 1 | Clock pad input value |
| sclk_pad_o | output | 1 | Clock pad output value |
| sclk_pad_oe | output | 1 | Clock pad output enable |
| sclk_spi_own | output | 1 | Clock pad owned by the port |
| mosi_pad_i | input | 1 | Master-out pad input value |
| mosi_pad_o | output | 1 | Master-out pad output value |
| mosi_pad_oe | output | 1 | Master-out pad output enable |
| mosi_spi_own | output | 1 | Master-out pad owned by the port |
| miso_pad_i | input | 1 | Master-in pad input value |
| miso_pad_o | output | 1 | Master-in pad output value |
| miso_pad_oe | output | 1 | Master-in pad output enable |
| miso_spi_own | output | 1 | Master-in pad owned by the port |
| ss_pad_n_i | input | 1 | Slave-select pad input, active low |
| ss_spi_own | output | 1 | Slave-select pad owned by the port |
| eng_sclk_drv | input | 1 | Clock produced by the engine in master role |
| eng_sclk_rx | output | 1 | Clock delivered to the engine in slave role |
| eng_tx | input | 1 | Engine serial output bit |
| eng_rx | output | 1 | Engine serial input bit |
| eng_ss_n | output | 1 | Slave-select delivered to the engine, active low |
| fault_ss_n | output | 1 | Slave-select delivered to the fault detector, active low |

## Verification
Every output is due in the same cycle as the input change, because no register lies on any path. The bench applies a new vector just after each rising edge and samples at the following falling edge, so the logic has half a period to settle before each compare. Its reference model steps through all 32 control combinations against all 64 patterns of the pad and engine inputs. It compares every output group on each of those cycles.

// File: rtl/spi_pin_pkg.sv
package spi_pin_pkg;

  typedef enum logic [2:0] {
    ROLE_OFF     = 3'd0,
    ROLE_MSTR_2W = 3'd1,
    ROLE_SLV_2W  = 3'd2,
    ROLE_MSTR_1W = 3'd3,
    ROLE_SLV_1W  = 3'd4
  } spi_role_e;

  typedef struct packed {
    logic own;
    logic oe;
  } pad_ctl_t;

  localparam int LANE_MOSI = 0;
  localparam int LANE_MISO = 1;
  localparam int NUM_LANES = 2;

  function automatic logic role_is_master(spi_role_e r);
    return (r == ROLE_MSTR_2W) || (r == ROLE_MSTR_1W);
  endfunction

  function automatic logic role_is_slave(spi_role_e r);
    return (r == ROLE_SLV_2W) || (r == ROLE_SLV_1W);
  endfunction

  // Ownership and direction of a data lane for a given role.
  function automatic pad_ctl_t lane_ctl(spi_role_e r, int lane, logic drive);
    pad_ctl_t c;
    c = '{own: 1'b0, oe: 1'b0};
    case (r)
      ROLE_MSTR_2W: c = '{own: 1'b1, oe: (lane == LANE_MOSI)};
      ROLE_SLV_2W:  c = '{own: 1'b1, oe: (lane == LANE_MISO)};
      ROLE_MSTR_1W: c = '{own: (lane == LANE_MOSI), oe: (lane == LANE_MOSI) && drive};
      ROLE_SLV_1W:  c = '{own: (lane == LANE_MISO), oe: (lane == LANE_MISO) && drive};
      default:      c = '{own: 1'b0, oe: 1'b0};
    endcase
    return c;
  endfunction

  // Which lane feeds the engine serial input.
  function automatic int rx_lane(spi_role_e r);
    case (r)
      ROLE_MSTR_2W: return LANE_MISO;
      ROLE_SLV_2W:  return LANE_MOSI;
      ROLE_MSTR_1W: return LANE_MOSI;
      ROLE_SLV_1W:  return LANE_MISO;
      default:      return LANE_MOSI;
    endcase
  endfunction

endpackage

// File: rtl/spi_role_decode.sv
module spi_role_decode
  import spi_pin_pkg::*;
(
  input  logic      en,
  input  logic      master,
  input  logic      one_wire,
  output spi_role_e role
);
  always_comb begin
    if (!en)
      role = ROLE_OFF;
    else if (master)
      role = one_wire ? ROLE_MSTR_1W : ROLE_MSTR_2W;
    else
      role = one_wire ? ROLE_SLV_1W : ROLE_SLV_2W;
  end
endmodule

// File: rtl/spi_data_lanes.sv
module spi_data_lanes
  import spi_pin_pkg::*;
#(
  parameter logic IDLE_RX = 1'b0
) (
  input  spi_role_e              role,
  input  logic                   drive,
  input  logic                   tx,
  input  logic [NUM_LANES-1:0]   pad_i,
  output logic [NUM_LANES-1:0]   pad_o,
  output logic [NUM_LANES-1:0]   pad_oe,
  output logic [NUM_LANES-1:0]   own,
  output logic                   rx
);
  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    pad_ctl_t ctl;
    always_comb begin
      ctl       = lane_ctl(role, g, drive);
      own[g]    = ctl.own;
      pad_oe[g] = ctl.oe;
      pad_o[g]  = ctl.oe ? tx : 1'b0;
    end
  end

  always_comb begin
    if (role == ROLE_OFF)
      rx = IDLE_RX;
    else
      rx = pad_i[rx_lane(role)];
  end
endmodule

// File: rtl/spi_ss_route.sv
module spi_ss_route
  import spi_pin_pkg::*;
#(
  parameter logic IDLE_SS_N = 1'b1
) (
  input  spi_role_e role,
  input  logic      fault_en,
  input  logic      ss_n_i,
  output logic      own,
  output logic      eng_ss_n,
  output logic      fault_ss_n
);
  logic to_engine, to_fault;
  always_comb begin
    to_engine  = role_is_slave(role);
    to_fault   = role_is_master(role) && fault_en;
    own        = to_engine || to_fault;
    eng_ss_n   = to_engine ? ss_n_i : IDLE_SS_N;
    fault_ss_n = to_fault  ? ss_n_i : IDLE_SS_N;
  end
endmodule

// File: rtl/spi_pin_router.sv
module spi_pin_router
  import spi_pin_pkg::*;
#(
  parameter logic IDLE_SS_N = 1'b1,
  parameter logic IDLE_RX   = 1'b0
) (
  input  logic spi_en,
  input  logic mstr_sel,
  input  logic one_wire_sel,
  input  logic bidir_drive,
  input  logic fault_det_en,
  input  logic sclk_pad_i,
  output logic sclk_pad_o,
  output logic sclk_pad_oe,
  output logic sclk_spi_own,
  input  logic mosi_pad_i,
  output logic mosi_pad_o,
  output logic mosi_pad_oe,
  output logic mosi_spi_own,
  input  logic miso_pad_i,
  output logic miso_pad_o,
  output logic miso_pad_oe,
  output logic miso_spi_own,
  input  logic ss_pad_n_i,
  output logic ss_spi_own,
  input  logic eng_sclk_drv,
  output logic eng_sclk_rx,
  input  logic eng_tx,
  output logic eng_rx,
  output logic eng_ss_n,
  output logic fault_ss_n
);
  spi_role_e            role;
  logic [NUM_LANES-1:0] lane_i, lane_o, lane_oe, lane_own;

  spi_role_decode u_dec (
    .en       (spi_en),
    .master   (mstr_sel),
    .one_wire (one_wire_sel),
    .role     (role)
  );

  assign lane_i[LANE_MOSI] = mosi_pad_i;
  assign lane_i[LANE_MISO] = miso_pad_i;

  spi_data_lanes #(.IDLE_RX(IDLE_RX)) u_lanes (
    .role   (role),
    .drive  (bidir_drive),
    .tx     (eng_tx),
    .pad_i  (lane_i),
    .pad_o  (lane_o),
    .pad_oe (lane_oe),
    .own    (lane_own),
    .rx     (eng_rx)
  );

  assign mosi_pad_o   = lane_o[LANE_MOSI];
  assign mosi_pad_oe  = lane_oe[LANE_MOSI];
  assign mosi_spi_own = lane_own[LANE_MOSI];
  assign miso_pad_o   = lane_o[LANE_MISO];
  assign miso_pad_oe  = lane_oe[LANE_MISO];
  assign miso_spi_own = lane_own[LANE_MISO];

  spi_ss_route #(.IDLE_SS_N(IDLE_SS_N)) u_ss (
    .role       (role),
    .fault_en   (fault_det_en),
    .ss_n_i     (ss_pad_n_i),
    .own        (ss_spi_own),
    .eng_ss_n   (eng_ss_n),
    .fault_ss_n (fault_ss_n)
  );

  // Clock pad: driven as master, received as slave.
  always_comb begin
    sclk_spi_own = (role != ROLE_OFF);
    sclk_pad_oe  = role_is_master(role);
    sclk_pad_o   = sclk_pad_oe ? eng_sclk_drv : 1'b0;
    eng_sclk_rx  = role_is_slave(role) ? sclk_pad_i : 1'b0;
  end
endmodule

// File: rtl/spi_pin_router_chk.sv
module spi_pin_router_chk (
  input logic spi_en, mstr_sel, one_wire_sel, bidir_drive, fault_det_en,
  input logic sclk_pad_i, sclk_pad_o, sclk_pad_oe, sclk_spi_own,
  input logic mosi_pad_i, mosi_pad_o, mosi_pad_oe, mosi_spi_own,
  input logic miso_pad_i, miso_pad_o, miso_pad_oe, miso_spi_own,
  input logic ss_pad_n_i, ss_spi_own,
  input logic eng_sclk_drv, eng_sclk_rx, eng_tx, eng_rx, eng_ss_n, fault_ss_n
);
  logic known;
  assign known = !$isunknown({spi_en, mstr_sel, one_wire_sel, bidir_drive, fault_det_en,
                              sclk_pad_i, mosi_pad_i, miso_pad_i, ss_pad_n_i,
                              eng_sclk_drv, eng_tx});

  always_comb begin
    if (known) begin
      p_off_quiet_r1: assert (spi_en || !(sclk_spi_own || mosi_spi_own || miso_spi_own || ss_spi_own))
        else $error("R1: pad owned while disabled");
      p_sclk_dir_r2: assert (!spi_en || (sclk_pad_oe == mstr_sel))
        else $error("R2: clock direction wrong");
      p_two_wire_dir_r3: assert (!(spi_en && mstr_sel && !one_wire_sel) || (mosi_pad_oe && !miso_pad_oe))
        else $error("R3: two-wire master data direction wrong");
      p_one_wire_pad_r5: assert (!(spi_en && one_wire_sel) || ((mosi_spi_own != miso_spi_own) && (mosi_spi_own == mstr_sel)))
        else $error("R5: one-wire pad choice wrong");
      p_bidir_oe_r7: assert (!(spi_en && one_wire_sel) || ((mosi_pad_oe || miso_pad_oe) == bidir_drive))
        else $error("R7: shared pad direction wrong");
      p_loopback_r8: assert (!(spi_en && one_wire_sel) || (eng_rx == (mstr_sel ? mosi_pad_i : miso_pad_i)))
        else $error("R8: one-wire receive source wrong");
      p_ss_fault_r11: assert (!(spi_en && mstr_sel && fault_det_en) || (fault_ss_n == ss_pad_n_i && eng_ss_n))
        else $error("R11: fault slave-select route wrong");
      p_release_r12: assert ((mosi_spi_own || (!mosi_pad_oe && !mosi_pad_o)) &&
                             (miso_spi_own || (!miso_pad_oe && !miso_pad_o)) &&
                             (sclk_spi_own || (!sclk_pad_oe && !sclk_pad_o)))
        else $error("R12: released pad still driven");
    end
  end
endmodule

bind spi_pin_router spi_pin_router_chk u_chk (
  .spi_en(spi_en), .mstr_sel(mstr_sel), .one_wire_sel(one_wire_sel),
  .bidir_drive(bidir_drive), .fault_det_en(fault_det_en),
  .sclk_pad_i(sclk_pad_i), .sclk_pad_o(sclk_pad_o), .sclk_pad_oe(sclk_pad_oe), .sclk_spi_own(sclk_spi_own),
  .mosi_pad_i(mosi_pad_i), .mosi_pad_o(mosi_pad_o), .mosi_pad_oe(mosi_pad_oe), .mosi_spi_own(mosi_spi_own),
  .miso_pad_i(miso_pad_i), .miso_pad_o(miso_pad_o), .miso_pad_oe(miso_pad_oe), .miso_spi_own(miso_spi_own),
  .ss_pad_n_i(ss_pad_n_i), .ss_spi_own(ss_spi_own),
  .eng_sclk_drv(eng_sclk_drv), .eng_sclk_rx(eng_sclk_rx), .eng_tx(eng_tx), .eng_rx(eng_rx),
  .eng_ss_n(eng_ss_n), .fault_ss_n(fault_ss_n)
);

// File: tb/test_spi_pin_router.sv
`timescale 1ns/1ps
module test_spi_pin_router;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic spi_en, mstr_sel, one_wire_sel, bidir_drive, fault_det_en;
  logic sclk_pad_i, sclk_pad_o, sclk_pad_oe, sclk_spi_own;
  logic mosi_pad_i, mosi_pad_o, mosi_pad_oe, mosi_spi_own;
  logic miso_pad_i, miso_pad_o, miso_pad_oe, miso_spi_own;
  logic ss_pad_n_i, ss_spi_own;
  logic eng_sclk_drv, eng_sclk_rx, eng_tx, eng_rx, eng_ss_n, fault_ss_n;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit done = 1'b0;

  spi_pin_router i_spi_pin_router (.*);

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual=%b expected=%b (ctl=%b%b%b%b%b)", tag, act, exp,
               spi_en, mstr_sel, one_wire_sel, bidir_drive, fault_det_en);
    end
  endtask

  // Reference model, written from the requirements.
  task automatic check_all();
    logic [7:0] e_sclk, e_data, e_ss;
    string t_sclk, t_data, t_ss;
    logic m_own, m_oe, m_o, s_own, s_oe, s_o, rx;
    m_own = 0; m_oe = 0; m_o = 0; s_own = 0; s_oe = 0; s_o = 0; rx = 0;
    if (!spi_en) begin
      e_sclk = 8'b0; t_sclk = "R1"; t_data = "R1"; t_ss = "R1";
      e_ss = {5'b0, 1'b0, 1'b1, 1'b1};
    end else begin
      t_sclk = "R2";
      if (mstr_sel) e_sclk = {4'b0, 1'b1, 1'b1, eng_sclk_drv, 1'b0};
      else          e_sclk = {4'b0, 1'b1, 1'b0, 1'b0, sclk_pad_i};
      if (!one_wire_sel) begin
        m_own = 1; s_own = 1;
        if (mstr_sel) begin t_data = "R3"; m_oe = 1; m_o = eng_tx; rx = miso_pad_i; end
        else          begin t_data = "R4"; s_oe = 1; s_o = eng_tx; rx = mosi_pad_i; end
      end else if (mstr_sel) begin
        t_data = bidir_drive ? "R5 R7" : "R5 R8";
        m_own = 1; m_oe = bidir_drive; m_o = bidir_drive & eng_tx; rx = mosi_pad_i;
      end else begin
        t_data = bidir_drive ? "R6 R7" : "R6 R8";
        s_own = 1; s_oe = bidir_drive; s_o = bidir_drive & eng_tx; rx = miso_pad_i;
      end
      if (!mstr_sel)          begin t_ss = "R9";  e_ss = {5'b0, 1'b1, ss_pad_n_i, 1'b1}; end
      else if (!fault_det_en) begin t_ss = "R10"; e_ss = {5'b0, 1'b0, 1'b1, 1'b1}; end
      else                    begin t_ss = "R11"; e_ss = {5'b0, 1'b1, 1'b1, ss_pad_n_i}; end
    end
    e_data = {1'b0, m_own, m_oe, m_o, s_own, s_oe, s_o, rx};
    chk(t_sclk, {4'b0, sclk_spi_own, sclk_pad_oe, sclk_pad_o, eng_sclk_rx}, e_sclk);
    chk(t_data, {1'b0, mosi_spi_own, mosi_pad_oe, mosi_pad_o,
                 miso_spi_own, miso_pad_oe, miso_pad_o, eng_rx}, e_data);
    chk(t_ss, {5'b0, ss_spi_own, eng_ss_n, fault_ss_n}, e_ss);
    // R12: released pads are silent
    chk("R12", {5'b0, !mosi_spi_own & (mosi_pad_oe | mosi_pad_o),
                !miso_spi_own & (miso_pad_oe | miso_pad_o),
                !sclk_spi_own & (sclk_pad_oe | sclk_pad_o)}, 8'b0);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      failures++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    {spi_en, mstr_sel, one_wire_sel, bidir_drive, fault_det_en} = 5'b0;
    {sclk_pad_i, mosi_pad_i, miso_pad_i, eng_sclk_drv, eng_tx} = 5'b11111;
    ss_pad_n_i = 1'b0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_all(); // reset state: disabled, R1
    for (int c = 0; c < 32; c++) begin
      for (int p = 0; p < 64; p++) begin
        @(posedge clk); #0.5;
        {spi_en, mstr_sel, one_wire_sel, bidir_drive, fault_det_en} = c[4:0];
        {sclk_pad_i, mosi_pad_i, miso_pad_i, ss_pad_n_i, eng_sclk_drv, eng_tx} = p[5:0];
        @(negedge clk);
        check_all();
      end
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule